// File: doc/BRIEF.md
# Dual Interval Timer and Status Port Unit

This unit is the byte-wide register block of a legacy sound device that pairs two interval timers with a status, data and command port set that old FM-synthesis software expects. The host writes and reads single bytes through a small port map. A hidden timer-data register is reached through the data port, but only when the command byte selects it. Two 8-bit up-counters load from host-programmed values. They count a base tick (nominally 80 µs) and a slow tick (every fourth base tick, nominally 320 µs). Each expiry sets status bits: a maskable group and a non-maskable group. Each group has its own enable. The unit gathers interrupt causes into one interrupt-status byte and drives one interrupt line.

Host access is a plain write strobe with an address. There is no back-pressure: every write takes effect at the clock edge where `wr_en` is high. Reads are a combinational view of the addressed register and have no side effects. The `tick` input is a one-cycle enable that comes from an outside prescaler.

Port map (`addr`): 0 reads the status view and writes the command byte. 1 reads and writes the data byte. 2 writes the plain status byte and reads back the command byte. 3 is the function select. 4 is the function data. 5 reads the interrupt-status byte. The function codes are 0x45 (timer control), 0x46 (timer 1 load value) and 0x47 (timer 2 load value).

Top module: `dual_timer_status`

## Requirements
- R1: After reset every register is zero and `irq` is low. A function-data read (addr 4) with any code other than 0x45, 0x46 or 0x47 returns 0xFF, as does a read of addr 6 or 7.
- R2: A read of addr 0 returns the timer status byte when timer-control bit 0 is 1. When that bit is 0 it returns the plain status byte last written at addr 2.
- R3: A write to addr 1 takes the timer path when the command byte is 0x04 and timer-control bit 0 is 0. On that path, data with bit 7 set clears status bits 7..5, and any other value becomes timer data. The timer-data fields are: bit 0 starts timer 1, bit 1 starts timer 2, bit 6 masks timer 1, bit 5 masks timer 2. A timer-path write leaves the data byte unchanged.
- R4: Any other write to addr 1 stores the data byte. If timer-control bit 1 is set, the same write also sets status bit 0, loads 0x10 into the interrupt-status byte and raises `irq` at that edge.
- R5: A timer-control write applies two clears. With bit 5 clear it clears status bits 4 and 3. With bit 1 clear it clears status bit 0. If status bits 0, 3 and 4 are then all zero, interrupt-status bit 4 is cleared.
- R6: A timer-control write with bit 2 clear clears status bit 2 and interrupt-status bit 2. With bit 3 clear it clears status bit 1 and interrupt-status bit 3.
- R7: While its start bit is 1, timer 1 adds one on each base tick. It expires on the tick that finds 0xFF, which is the (256 − load value)th tick, and then reloads. While its start bit is 0 it holds the load value.
- R8: A divider counts every base tick from reset. Each fourth base tick (the 4th, 8th, and so on) is a slow tick, and timer 2 counts slow ticks under the same rules as timer 1.
- R9: On timer 1 expiry, status bits 7 and 6 are set unless timer-data bit 6 is 1. If timer-control bit 2 is 1, status bit 2 and interrupt-status bit 2 are set as well. Expiry is applied after a host write in the same cycle.
- R10: On timer 2 expiry, status bits 7 and 5 are set unless timer-data bit 5 is 1. If timer-control bit 3 is 1, status bit 1 and interrupt-status bit 3 are set as well.
- R11: After every clock edge, `irq` is high exactly when the interrupt-status byte is nonzero.
- R12: Function data reads back timer control under 0x45, the timer 1 load value under 0x46 and the timer 2 load value under 0x47. Addr 3 reads back the function select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle base tick enable from the prescaler |
| wr_en | input | 1 | Host write strobe, taken in the cycle it is high |
| addr | input | 3 | Host port select |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Combinational read byte for `addr` |
| irq | output | 1 | Interrupt line, high while any interrupt-status bit is set |

## Verification
The assertions assume that `wr_en`, `addr`, `wdata` and `tick` are known (never X) whenever reset is released. They also assume that a host write and an expiry in the same cycle are resolved write-first, then expiry. The bench changes every input only on the falling clock edge. It holds inputs at defined values from time zero and drives `tick` as a single-cycle level. Directed sequences place the timer-path and data-path writes where the command byte and control bit 0 decide between them. A pseudo-random phase then mixes writes and ticks across all addresses, including the unmapped ones.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NTMR = 2;

  typedef enum logic [2:0] {
    P_STATUS = 3'd0,
    P_DATA   = 3'd1,
    P_AUX    = 3'd2,
    P_FSEL   = 3'd3,
    P_FDATA  = 3'd4,
    P_ISTAT  = 3'd5
  } port_e;

  localparam logic [DW-1:0] FN_TCTL   = 8'h45;
  localparam logic [DW-1:0] FN_LOAD1  = 8'h46;
  localparam logic [DW-1:0] FN_LOAD2  = 8'h47;
  localparam logic [DW-1:0] CMD_TIMER = 8'h04;
  localparam logic [DW-1:0] RD_NONE   = 8'hFF;
endpackage

// File: rtl/dts_tick_div.sv
module dts_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_slow
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (tick_in) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick_slow = tick_in && (cnt == LAST);
endmodule

// File: rtl/dts_counter.sv
module dts_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         expire
);
  logic [W-1:0] cnt;
  wire at_top = (cnt == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= reload;
    else if (step) cnt <= at_top ? reload : cnt + 1'b1;
  end

  assign expire = run && step && at_top;

  // R7: an expiry restarts the count from the load value
  assert_reload_on_expire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> cnt == $past(reload));
  // R7: a stopped timer sits at its load value
  assert_hold_when_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == $past(reload));
endmodule

// File: rtl/dts_regs.sv
module dts_regs
  import dts_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          exp1,
  input  logic          exp2,
  output logic [DW-1:0] rdata,
  output logic [1:0]    run,
  output logic [DW-1:0] load1,
  output logic [DW-1:0] load2,
  output logic          irq
);
  logic [DW-1:0] tctl, cmd, fm_data, fm_stat, fsel, status, istat;
  logic [1:0]    td_run, td_mask;   // td_mask[1]: timer 1 mask, td_mask[0]: timer 2 mask
  logic [DW-1:0] n_tctl, n_cmd, n_fm_data, n_fm_stat, n_fsel, n_status, n_istat, n_load1, n_load2;
  logic [1:0]    n_td_run, n_td_mask;

  wire timer_path = (cmd == CMD_TIMER) && !tctl[0];

  always_comb begin
    n_tctl = tctl; n_cmd = cmd; n_fm_data = fm_data; n_fm_stat = fm_stat;
    n_fsel = fsel; n_status = status; n_istat = istat;
    n_load1 = load1; n_load2 = load2; n_td_run = td_run; n_td_mask = td_mask;
    if (wr_en) begin
      case (addr)
        P_STATUS: n_cmd = wdata;
        P_DATA: begin
          if (timer_path) begin
            if (wdata[7]) n_status[7:5] = 3'b000;
            else begin
              n_td_run  = wdata[1:0];
              n_td_mask = {wdata[6], wdata[5]};
            end
          end else begin
            n_fm_data = wdata;
            if (tctl[1]) begin
              n_status[0] = 1'b1;
              n_istat     = 8'h10;
            end
          end
        end
        P_AUX:  n_fm_stat = wdata;
        P_FSEL: n_fsel = wdata;
        P_FDATA: begin
          case (fsel)
            FN_TCTL: begin
              n_tctl = wdata;
              if (!wdata[5]) n_status[4:3] = 2'b00;
              if (!wdata[1]) n_status[0] = 1'b0;
              if (n_status[4:3] == 2'b00 && !n_status[0]) n_istat[4] = 1'b0;
              if (!wdata[2]) begin n_status[2] = 1'b0; n_istat[2] = 1'b0; end
              if (!wdata[3]) begin n_status[1] = 1'b0; n_istat[3] = 1'b0; end
            end
            FN_LOAD1: n_load1 = wdata;
            FN_LOAD2: n_load2 = wdata;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
    if (exp1) begin
      if (!td_mask[1]) n_status[7:6] = 2'b11;
      if (tctl[2]) begin n_status[2] = 1'b1; n_istat[2] = 1'b1; end
    end
    if (exp2) begin
      if (!td_mask[0]) begin n_status[7] = 1'b1; n_status[5] = 1'b1; end
      if (tctl[3]) begin n_status[1] = 1'b1; n_istat[3] = 1'b1; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tctl <= '0; cmd <= '0; fm_data <= '0; fm_stat <= '0; fsel <= '0;
      status <= '0; istat <= '0; load1 <= '0; load2 <= '0;
      td_run <= '0; td_mask <= '0; irq <= 1'b0;
    end else begin
      tctl <= n_tctl; cmd <= n_cmd; fm_data <= n_fm_data; fm_stat <= n_fm_stat;
      fsel <= n_fsel; status <= n_status; istat <= n_istat;
      load1 <= n_load1; load2 <= n_load2;
      td_run <= n_td_run; td_mask <= n_td_mask;
      irq <= |n_istat;
    end
  end

  always_comb begin
    case (addr)
      P_STATUS: rdata = tctl[0] ? status : fm_stat;
      P_DATA:   rdata = fm_data;
      P_AUX:    rdata = cmd;
      P_FSEL:   rdata = fsel;
      P_FDATA: begin
        case (fsel)
          FN_TCTL:  rdata = tctl;
          FN_LOAD1: rdata = load1;
          FN_LOAD2: rdata = load2;
          default:  rdata = RD_NONE;
        endcase
      end
      P_ISTAT:  rdata = istat;
      default:  rdata = RD_NONE;
    endcase
  end

  assign run = td_run;

  // R11: line is released once no cause remains
  assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (istat == 8'h00) |-> !irq);
  // R4: data write with its enable raises the shared line
  assert_fm_write_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == P_DATA && !timer_path && tctl[1]) |=> (istat[4] && irq));
  // R6: disabling timer 1 interrupt drops its non-maskable flags
  assert_t1_disable_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == P_FDATA && fsel == FN_TCTL && !wdata[2] && !exp1)
      |=> (!status[2] && !istat[2]));
  // R9: unmasked timer 1 expiry shows in the maskable group
  assert_t1_maskable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exp1 && !td_mask[1]) |=> (status[7:6] == 2'b11));
  // R10: unmasked timer 2 expiry shows in the maskable group
  assert_t2_maskable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exp2 && !td_mask[0]) |=> (status[7] && status[5]));
endmodule

// File: rtl/dual_timer_status.sv
module dual_timer_status
  import dts_pkg::*;
#(
  parameter int unsigned SLOW_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  logic [NTMR-1:0] step, expire, run;
  logic [DW-1:0]   load1, load2;
  logic [DW-1:0]   reload [NTMR];
  logic            tick_slow;

  dts_tick_div #(.DIV(SLOW_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_in(tick), .tick_slow(tick_slow)
  );

  assign step[0]   = tick;
  assign step[1]   = tick_slow;
  assign reload[0] = load1;
  assign reload[1] = load2;

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    dts_counter #(.W(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run[g]), .step(step[g]),
      .reload(reload[g]), .expire(expire[g])
    );
  end

  dts_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .exp1(expire[0]), .exp2(expire[1]), .rdata(rdata), .run(run),
    .load1(load1), .load2(load2), .irq(irq)
  );
endmodule

// File: tb/dual_timer_status_bench.sv
module dual_timer_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  bit live = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  dual_timer_status u_dual_timer_status (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // behavioural reference state
  int m_tc, m_cmd, m_fd, m_fs, m_sel, m_st, m_is, m_r1, m_r2, m_td, m_c1, m_c2, m_div;
  bit m_irq;

  function automatic int mread(int a);
    case (a)
      0: return (m_tc & 1) ? m_st : m_fs;
      1: return m_fd;
      2: return m_cmd;
      3: return m_sel;
      4: return (m_sel == 'h45) ? m_tc : (m_sel == 'h46) ? m_r1 : (m_sel == 'h47) ? m_r2 : 'hFF;
      5: return m_is;
      default: return 'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tc = 0; m_cmd = 0; m_fd = 0; m_fs = 0; m_sel = 0; m_st = 0; m_is = 0;
      m_r1 = 0; m_r2 = 0; m_td = 0; m_c1 = 0; m_c2 = 0; m_div = 0; m_irq = 0;
    end else begin
      int o_tc, o_td, o_r1, o_r2, d;
      bit slow, e1, e2;
      o_tc = m_tc; o_td = m_td; o_r1 = m_r1; o_r2 = m_r2; d = int'(wdata);
      slow = tick && (m_div == 3);
      e1 = (o_td & 1) != 0 && tick && m_c1 == 255;
      e2 = (o_td & 2) != 0 && slow && m_c2 == 255;
      if (tick) m_div = (m_div + 1) % 4;
      if ((o_td & 1) == 0) m_c1 = o_r1; else if (tick) m_c1 = (m_c1 == 255) ? o_r1 : m_c1 + 1;
      if ((o_td & 2) == 0) m_c2 = o_r2; else if (slow) m_c2 = (m_c2 == 255) ? o_r2 : m_c2 + 1;
      if (wr_en) begin
        case (int'(addr))
          0: m_cmd = d;
          1: if (m_cmd == 4 && (o_tc & 1) == 0) begin
               if (d & 'h80) m_st = m_st & 'h1F; else m_td = d;
             end else begin
               m_fd = d;
               if (o_tc & 2) begin m_st = m_st | 1; m_is = 'h10; end
             end
          2: m_fs = d;
          3: m_sel = d;
          4: if (m_sel == 'h45) begin
               m_tc = d;
               if ((d & 'h20) == 0) m_st = m_st & 'hE7;
               if ((d & 2) == 0) m_st = m_st & 'hFE;
               if ((m_st & 'h19) == 0) m_is = m_is & 'hEF;
               if ((d & 4) == 0) begin m_st = m_st & 'hFB; m_is = m_is & 'hFB; end
               if ((d & 8) == 0) begin m_st = m_st & 'hFD; m_is = m_is & 'hF7; end
             end else if (m_sel == 'h46) m_r1 = d;
             else if (m_sel == 'h47) m_r2 = d;
          default: ;
        endcase
      end
      if (e1) begin
        if ((o_td & 'h40) == 0) m_st = m_st | 'hC0;
        if (o_tc & 4) begin m_st = m_st | 4; m_is = m_is | 4; end
      end
      if (e2) begin
        if ((o_td & 'h20) == 0) m_st = m_st | 'hA0;
        if (o_tc & 8) begin m_st = m_st | 2; m_is = m_is | 8; end
      end
      m_irq = (m_is != 0);
    end
  end

  task automatic chk(string t, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", t, act, exp);
    end
  endtask

  // R11 and every mapped register: model compared on each falling edge
  always @(negedge clk) begin
    if (live) begin
      chk({tag, " rdata vs model"}, int'(rdata), mread(int'(addr)));
      chk({tag, " R11 irq vs model"}, int'(irq), int'(m_irq));
    end
  end

  task automatic op(bit w, int a, int d, bit t);
    @(negedge clk);
    wr_en = w; addr = 3'(a); wdata = 8'(d); tick = t;
  endtask

  task automatic wr(int a, int d); op(1, a, d, 0); endtask
  task automatic fn(int code, int d); wr(3, code); wr(4, d); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) op(0, 0, 0, 1); endtask

  task automatic rd(int a, int exp, string t);
    op(0, a, 0, 0);
    #1 chk(t, int'(rdata), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;
    // R1: reset state
    tag = "R1";
    rd(0, 'h00, "R1 status after reset");
    rd(5, 'h00, "R1 istat after reset");
    chk("R1 irq after reset", int'(irq), 0);
    rd(4, 'hFF, "R1 unmapped function code 0x00");
    rd(7, 'hFF, "R1 unmapped port 7");
    // R12: function readback
    tag = "R12";
    fn('h46, 'hFD); rd(4, 'hFD, "R12 load1 readback");
    fn('h47, 'hFF); rd(4, 'hFF, "R12 load2 readback");
    fn('h45, 'h06); rd(4, 'h06, "R12 tctl readback");
    rd(3, 'h45, "R12 fsel readback");
    wr(3, 'h50); rd(4, 'hFF, "R12 code 0x50 reads 0xFF");
    wr(3, 'h45);
    // R4 and R2: data path with interrupt
    tag = "R4";
    wr(0, 'h10); wr(1, 'h5A);
    rd(1, 'h5A, "R4 data byte stored");
    rd(5, 'h10, "R4 istat loaded 0x10");
    chk("R4 irq raised", int'(irq), 1);
    tag = "R2";
    wr(2, 'h33); rd(0, 'h33, "R2 plain status view when tctl[0]=0");
    // R5: bit1 clear drops status0 and istat4
    tag = "R5";
    wr(4, 'h05);
    rd(0, 'h00, "R5 R2 timer status view after clear");
    rd(5, 'h00, "R5 istat bit4 cleared");
    chk("R5 R11 irq released", int'(irq), 0);
    // R3: timer path, data byte untouched
    tag = "R3";
    wr(4, 'h04); wr(0, 'h04); wr(1, 'h01);
    rd(1, 'h5A, "R3 timer write leaves data byte");
    // R7/R9: load 0xFD expires on third tick
    tag = "R7";
    ticks(2);
    wr(4, 'h05); rd(0, 'h00, "R7 no expiry after two ticks");
    wr(4, 'h04); ticks(1); wr(4, 'h05);
    rd(0, 'hC4, "R9 R7 timer1 expiry status");
    rd(5, 'h04, "R9 timer1 istat bit2");
    // R6: bit2 clear
    tag = "R6";
    wr(4, 'h01);
    rd(0, 'hC0, "R6 status bit2 cleared");
    rd(5, 'h00, "R6 istat bit2 cleared");
    // R3: bit7 clears top three bits
    tag = "R3";
    wr(4, 'h00); wr(1, 'h80); wr(4, 'h01);
    rd(0, 'h00, "R3 bit7 write clears status 7..5");
    // R9: masked timer1 (reload keeps running count; restart)
    tag = "R9";
    wr(4, 'h00); wr(1, 'h00); wr(1, 'h41); wr(4, 'h05);
    ticks(3);
    rd(0, 'h04, "R9 masked timer1 sets only bit2");
    // R8/R10: 6 ticks so far; slow tick is the 8th
    tag = "R8";
    wr(4, 'h00); wr(1, 'h02); wr(4, 'h09);
    ticks(1);
    rd(0, 'h00, "R8 no slow tick on 7th base tick");
    ticks(1);
    rd(0, 'hA2, "R10 R8 timer2 expiry on 8th base tick");
    rd(5, 'h08, "R10 timer2 istat bit3");
    tag = "R6";
    wr(4, 'h01);
    rd(0, 'hA0, "R6 status bit1 cleared");
    rd(5, 'h00, "R6 istat bit3 cleared");
    // R3 boundary: tctl[0]=1 sends data write to data byte even with cmd 0x04
    tag = "R3";
    wr(1, 'h77);
    rd(1, 'h77, "R3 tctl[0]=1 selects data byte");
    rd(5, 'h00, "R4 no interrupt when tctl[1]=0");
    // mixed traffic against the model
    tag = "R11 mixed";
    begin
      int unsigned s = 32'h1234_5678;
      for (int i = 0; i < 3000; i++) begin
        s = s * 1103515245 + 12345;
        case ((s >> 8) % 8)
          0, 1: op(0, 0, 0, 1);
          2: wr(0, ((s >> 16) & 1) ? 4 : int'((s >> 20) & 'hFF));
          3: wr(1, int'((s >> 12) & 'hFF));
          4: fn('h45 + int'((s >> 16) % 3), int'((s >> 20) & 'hFF));
          5: wr(int'((s >> 16) % 8), int'((s >> 24) & 'hFF));
          default: op(0, int'((s >> 16) % 8), 0, (s >> 22) & 1);
        endcase
      end
    end
    op(0, 0, 0, 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule